// File: doc/BRIEF.md
# SD Card Clock Divider with Gating

This block derives the SD card clock from the reference clock it runs on, nominally 50 MHz. The divisor is an 8-bit value. Software writes a target rate in hertz. The block picks the nearest divisor that does not exceed that rate, after first limiting the target to a configurable maximum.

A small policy stage chooses the divisor actually in use and decides whether the clock may run. After the card is powered, a slow start-up rate near 1 MHz is forced until the first bulk transfer completes cleanly. A slow-mode input multiplies the divisor by a ratio. By default the clock is gated off whenever no transaction is active. An idle-enable input keeps it running between transactions. With card power off the clock is always held low.

A divisor change is never applied to a running divider. The sequencer first lets the current period finish, then stops the divider and loads the new value. It restarts only after the load. While a transaction is active, a change is held back until the bus is idle.

Top module: `sdclk_ctrl`

## Requirements
- R1: While running, `sd_clk` repeats with a period of exactly `div_now`+1 reference cycles; `div_now` is 8 bits wide.
- R2: Outside the start-up phase and without slow mode, the divisor is the smallest d in 0..255 with floor(50000000/(d+1)) <= the limited target; if no d qualifies it is 255.
- R3: `div_now` changes only while the divider is stopped: `clk_on` is low in the cycle before the change and in the cycle of the change.
- R4: A rising `card_pwr` starts a start-up phase whose divisor is 49 (about 1 MHz). In this phase the clock runs even with no transaction. The phase ends only on a `bulk_done` pulse with `bulk_err` low; a pulse with `bulk_err` high leaves it in place.
- R5: With `slow_req` high, outside the start-up phase, the divisor is min(8 × base divisor, 255).
- R6: The clock runs only while powered and (`xfer_busy` or `idle_clk_en` or start-up phase). When that condition drops, the current period completes and the clock then stays low with `clk_on` low.
- R7: In the cycle after `card_pwr` is sampled low, `sd_clk` and `clk_on` are low, and they stay low while power is off.
- R8: Targets above 50000000/3 Hz are limited to that rate, giving divisor 2.
- R9: Each period starts with floor((`div_now`+1)/2) high cycles; the remaining cycles are low.
- R10: While `xfer_busy` is high and the clock runs, a new target leaves `div_now` and the period unchanged; the change takes effect after `xfer_busy` falls.
- R11: After reset, `sd_clk` and `clk_on` are low and `div_now` is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the divider input |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_we | input | 1 | Write strobe for the target rate |
| req_hz | input | 32 | Target card clock rate in hertz |
| card_pwr | input | 1 | Card power is on |
| xfer_busy | input | 1 | A transaction is in progress |
| bulk_done | input | 1 | Pulse: a bulk transfer has finished |
| bulk_err | input | 1 | Qualifies `bulk_done`: the transfer failed |
| idle_clk_en | input | 1 | Keep the clock running between transactions |
| slow_req | input | 1 | Apply the slow-ratio multiplier |
| sd_clk | output | 1 | Divided, gated card clock |
| clk_on | output | 1 | The divider is running |
| div_now | output | 8 | Divisor currently loaded in the divider |

## Verification
A wrong counter or a stale divisor shows up as a wrong `sd_clk` period or high time. This appears within one period of the change, which is at most 256 reference cycles. A start-up flag that is stuck or cleared by the wrong event shows up as the wrong `div_now` within a few cycles. It also shows as a clock that runs, or fails to run, with no transaction. A load while the divider runs, or a clock pulse while unpowered, is caught by sampling `clk_on`, `div_now` and `sd_clk` every cycle.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   // Divider phase
   typedef enum logic {
      PH_STOPPED = 1'b0,
      PH_RUNNING = 1'b1
   } sdclk_phase_e;

   // Smallest divisor d (0..dmax) whose rate ref_hz/(d+1) does not exceed hz.
   function automatic int unsigned sdclk_const_div(input int unsigned ref_hz,
                                                   input int unsigned hz,
                                                   input int unsigned dmax);
      int unsigned r;
      r = dmax;
      for (int d = int'(dmax); d >= 0; d--) begin
         if ((ref_hz / unsigned'(d + 1)) <= hz) r = unsigned'(d);
      end
      return r;
   endfunction

endpackage

// File: rtl/sdclk_divsel.sv
module sdclk_divsel #(
   parameter int unsigned REF_HZ = 50_000_000,
   parameter int unsigned MAX_HZ = 50_000_000 / 3,
   parameter int unsigned DIV_W  = 8,
   parameter int unsigned FREQ_W = 32
) (
   input  logic [FREQ_W-1:0] req_hz_i,
   output logic [DIV_W-1:0]  div_o
);
   localparam int unsigned NDIV = 1 << DIV_W;

   logic [FREQ_W-1:0] lim_hz;
   logic [NDIV-1:0]   fits;

   // Limit target to the top supported rate
   assign lim_hz = (req_hz_i > FREQ_W'(MAX_HZ)) ? FREQ_W'(MAX_HZ) : req_hz_i;

   // One constant threshold comparator per candidate divisor
   generate
      for (genvar d = 0; d < NDIV; d++) begin : g_thr
         localparam logic [FREQ_W-1:0] THR = FREQ_W'(REF_HZ / (d + 1));
         assign fits[d] = (THR <= lim_hz);
      end
   endgenerate

   // Lowest fitting divisor wins; none fitting gives the largest divisor
   always_comb begin
      div_o = DIV_W'(NDIV - 1);
      for (int d = int'(NDIV) - 1; d >= 0; d--) begin
         if (fits[d]) div_o = DIV_W'(d);
      end
   end

endmodule

// File: rtl/sdclk_policy.sv
module sdclk_policy #(
   parameter int unsigned DIV_W      = 8,
   parameter int unsigned SLOW_RATIO = 8,
   parameter int unsigned PU_DIV     = 49
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_i,
   input  logic             busy_i,
   input  logic             idle_en_i,
   input  logic             slow_i,
   input  logic             bulk_done_i,
   input  logic             bulk_err_i,
   input  logic [DIV_W-1:0] sel_div_i,
   output logic             want_o,
   output logic [DIV_W-1:0] target_o
);
   localparam int unsigned DMAX = (1 << DIV_W) - 1;

   logic             pwr_d;
   logic             pu_q;
   logic [DIV_W-1:0] slow_div;

   // Start-up phase: set on a power rising edge, cleared by a clean bulk completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_d <= 1'b0;
         pu_q  <= 1'b0;
      end else begin
         pwr_d <= pwr_i;
         if (!pwr_i)                          pu_q <= 1'b0;
         else if (!pwr_d)                     pu_q <= 1'b1;
         else if (bulk_done_i && !bulk_err_i) pu_q <= 1'b0;
      end
   end

   // Slow-ratio scaling, saturating at the largest divisor
   generate
      if (SLOW_RATIO > 1) begin : g_scale
         localparam int unsigned RW = $clog2(SLOW_RATIO + 1);
         localparam int unsigned PW = DIV_W + RW;
         logic [PW-1:0] prod;
         assign prod     = {{RW{1'b0}}, sel_div_i} * PW'(SLOW_RATIO);
         assign slow_div = (prod > PW'(DMAX)) ? DIV_W'(DMAX) : prod[DIV_W-1:0];
      end else begin : g_noscale
         assign slow_div = sel_div_i;
      end
   endgenerate

   always_comb begin
      if (pu_q)        target_o = DIV_W'(PU_DIV);
      else if (slow_i) target_o = slow_div;
      else             target_o = sel_div_i;
   end

   assign want_o = pwr_i && (busy_i || idle_en_i || pu_q);

   // R4: power rising starts the start-up phase
   a_r4_pu_set: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_i && !pwr_d) |=> (target_o == DIV_W'(PU_DIV)));

   // R4: only a clean completion ends the start-up phase
   a_r4_pu_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pu_q && pwr_i && !(bulk_done_i && !bulk_err_i)) |=> pu_q);

   // R6: no run request without power
   a_r6_want_pwr: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_i |-> !want_o);

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
   import sdclk_pkg::*;
#(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_i,
   input  logic             busy_i,
   input  logic             want_i,
   input  logic [DIV_W-1:0] target_i,
   output logic             sd_clk_o,
   output logic             run_o,
   output logic [DIV_W-1:0] div_o
);
   sdclk_phase_e     phase_q;
   logic             out_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_q;

   logic [DIV_W:0]   period_len;
   logic [DIV_W:0]   hi_len;
   logic [DIV_W:0]   cnt_inc;
   logic             pend;
   logic             stop_req;
   logic             last;
   logic             running;

   assign running    = (phase_q == PH_RUNNING);
   assign period_len = {1'b0, div_q} + (DIV_W + 1)'(1);
   assign hi_len     = period_len >> 1;
   assign cnt_inc    = {1'b0, cnt_q} + (DIV_W + 1)'(1);
   assign pend       = (target_i != div_q);
   assign last       = (cnt_q == div_q);
   // Stop when gated off, or when a change is pending and the bus is idle
   assign stop_req   = !want_i || (pend && !busy_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_STOPPED;
         out_q   <= 1'b0;
         cnt_q   <= '0;
         div_q   <= '1;
      end else if (!pwr_i) begin
         phase_q <= PH_STOPPED;
         out_q   <= 1'b0;
         cnt_q   <= '0;
      end else if (running) begin
         if (last) begin
            cnt_q <= '0;
            if (stop_req) begin
               phase_q <= PH_STOPPED;
               out_q   <= 1'b0;
            end else begin
               out_q <= 1'b1;
            end
         end else begin
            cnt_q <= cnt_inc[DIV_W-1:0];
            out_q <= (cnt_inc < hi_len);
         end
      end else begin
         out_q <= 1'b0;
         cnt_q <= '0;
         if (pend) begin
            div_q <= target_i;          // load only with the divider stopped
         end else if (want_i) begin
            phase_q <= PH_RUNNING;
            out_q   <= 1'b1;
         end
      end
   end

   assign sd_clk_o = out_q;
   assign run_o    = running;
   assign div_o    = div_q;

   // R3: divisor changes only across stopped cycles
   a_r3_load_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_q) |-> (!running && !$past(running)));

   // R7: no clock after power is seen low
   a_r7_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_i |=> (!out_q && !running));

   // R10: divisor held while a transaction runs
   a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (running && busy_i && pwr_i) |=> $stable(div_q));

   // R1: counter stays within the loaded period
   a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt_q <= div_q));

   // R9: every period opens with a high phase
   a_r9_high_first: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt_q == '0) |-> out_q);

   // R6: a stopped divider drives no clock
   a_r6_low_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !out_q);

endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
   import sdclk_pkg::*;
#(
   parameter int unsigned REF_HZ     = 50_000_000,
   parameter int unsigned MAX_HZ     = REF_HZ / 3,
   parameter int unsigned PU_HZ      = 1_000_000,
   parameter int unsigned SLOW_RATIO = 8,
   parameter int unsigned DIV_W      = 8,
   parameter int unsigned FREQ_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_we,
   input  logic [FREQ_W-1:0] req_hz,
   input  logic              card_pwr,
   input  logic              xfer_busy,
   input  logic              bulk_done,
   input  logic              bulk_err,
   input  logic              idle_clk_en,
   input  logic              slow_req,
   output logic              sd_clk,
   output logic              clk_on,
   output logic [DIV_W-1:0]  div_now
);
   localparam int unsigned DMAX   = (1 << DIV_W) - 1;
   localparam int unsigned PU_DIV = sdclk_const_div(REF_HZ, PU_HZ, DMAX);

   // Elaboration-time parameter checks
   generate
      if (MAX_HZ * 2 > REF_HZ) begin : g_chk_max
         $error("MAX_HZ must not exceed half of REF_HZ");
      end
      if (PU_DIV < 1) begin : g_chk_pu
         $error("PU_HZ too high for a registered divider");
      end
      if (DIV_W < 2 || DIV_W > 12) begin : g_chk_w
         $error("DIV_W out of range");
      end
   endgenerate

   logic [FREQ_W-1:0] req_q;
   logic [DIV_W-1:0]  sel_div;
   logic [DIV_W-1:0]  target;
   logic              want;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      req_q <= FREQ_W'(MAX_HZ);
      else if (req_we) req_q <= req_hz;
   end

   sdclk_divsel #(
      .REF_HZ (REF_HZ),
      .MAX_HZ (MAX_HZ),
      .DIV_W  (DIV_W),
      .FREQ_W (FREQ_W)
   ) u_divsel (
      .req_hz_i (req_q),
      .div_o    (sel_div)
   );

   sdclk_policy #(
      .DIV_W      (DIV_W),
      .SLOW_RATIO (SLOW_RATIO),
      .PU_DIV     (PU_DIV)
   ) u_policy (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwr_i       (card_pwr),
      .busy_i      (xfer_busy),
      .idle_en_i   (idle_clk_en),
      .slow_i      (slow_req),
      .bulk_done_i (bulk_done),
      .bulk_err_i  (bulk_err),
      .sel_div_i   (sel_div),
      .want_o      (want),
      .target_o    (target)
   );

   sdclk_gen #(
      .DIV_W (DIV_W)
   ) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_i    (card_pwr),
      .busy_i   (xfer_busy),
      .want_i   (want),
      .target_i (target),
      .sd_clk_o (sd_clk),
      .run_o    (clk_on),
      .div_o    (div_now)
   );

   // R11: reset leaves the card clock quiet
   a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!sd_clk && !clk_on));

endmodule

// File: tb/sdclk_ctrl_tb.sv
module sdclk_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_we = 1'b0;
   logic [31:0] req_hz = '0;
   logic        card_pwr = 1'b0;
   logic        xfer_busy = 1'b0;
   logic        bulk_done = 1'b0;
   logic        bulk_err = 1'b0;
   logic        idle_clk_en = 1'b0;
   logic        slow_req = 1'b0;
   logic        sd_clk;
   logic        clk_on;
   logic [7:0]  div_now;

   int n_chk = 0;
   int n_fail = 0;

   // Monitor state
   logic [7:0] mon_div_prev = 8'hff;
   logic       mon_on_prev = 1'b0;
   logic       mon_pwr_prev = 1'b0;
   int         mon_loads = 0;
   int         mon_bad_load = 0;
   int         mon_pwr_viol = 0;

   always #2 clk = ~clk;   // 250 MHz

   sdclk_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_we      (req_we),
      .req_hz      (req_hz),
      .card_pwr    (card_pwr),
      .xfer_busy   (xfer_busy),
      .bulk_done   (bulk_done),
      .bulk_err    (bulk_err),
      .idle_clk_en (idle_clk_en),
      .slow_req    (slow_req),
      .sd_clk      (sd_clk),
      .clk_on      (clk_on),
      .div_now     (div_now)
   );

   // R3 / R7 monitors, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (div_now != mon_div_prev) begin
            mon_loads++;
            if (clk_on || mon_on_prev) mon_bad_load++;
         end
         if (!mon_pwr_prev && !card_pwr && (sd_clk || clk_on)) mon_pwr_viol++;
      end
      mon_div_prev = div_now;
      mon_on_prev  = clk_on;
      mon_pwr_prev = card_pwr;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_div(input int unsigned hz);
      int unsigned lim;
      lim = (hz > 50000000 / 3) ? 50000000 / 3 : hz;
      for (int d = 0; d < 256; d++) begin
         if (50000000 / (d + 1) <= lim) return d;
      end
      return 255;
   endfunction

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_rate(input int unsigned hz);
      @(negedge clk);
      req_hz = hz;
      req_we = 1'b1;
      @(negedge clk);
      req_we = 1'b0;
   endtask

   // Measure one full period: high count and total length
   task automatic measure(output int hi, output int per);
      int guard;
      hi = 0;
      per = 0;
      guard = 0;
      while (sd_clk && guard < 1000) begin @(negedge clk); guard++; end
      while (!sd_clk && guard < 1000) begin @(negedge clk); guard++; end
      while (sd_clk && guard < 1000) begin @(negedge clk); hi++; per++; guard++; end
      while (!sd_clk && guard < 1000) begin @(negedge clk); per++; guard++; end
   endtask

   task automatic check_quiet(input int n, input string tag);
      int highs;
      highs = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (sd_clk || clk_on) highs++;
      end
      check(highs == 0, tag, highs, 0);
   endtask

   task automatic t_reset;
      cycles(2);
      rst_n = 1'b1;
      cycles(2);
      check(sd_clk == 1'b0, "R11 sd_clk after reset", sd_clk, 0);
      check(clk_on == 1'b0, "R11 clk_on after reset", clk_on, 0);
      check(div_now == 8'd255, "R11 divisor after reset", div_now, 255);
   endtask

   task automatic t_power_off;
      write_rate(10_000_000);
      xfer_busy = 1'b1;
      idle_clk_en = 1'b1;
      check_quiet(60, "R7 no clock while unpowered");
      xfer_busy = 1'b0;
      idle_clk_en = 1'b0;
   endtask

   task automatic t_powerup_slow;
      int hi, per;
      card_pwr = 1'b1;
      cycles(10);
      check(div_now == 8'd49, "R4 start-up divisor", div_now, 49);
      check(clk_on == 1'b1, "R4 runs with no transaction", clk_on, 1);
      measure(hi, per);
      check(per == 50, "R4 start-up period", per, 50);
      // error completion keeps the start-up phase
      @(negedge clk);
      bulk_done = 1'b1;
      bulk_err = 1'b1;
      @(negedge clk);
      bulk_done = 1'b0;
      bulk_err = 1'b0;
      cycles(120);
      check(div_now == 8'd49 && clk_on, "R4 errored completion ignored", div_now, 49);
   endtask

   task automatic t_bulk_ok;
      @(negedge clk);
      bulk_done = 1'b1;
      @(negedge clk);
      bulk_done = 1'b0;
      cycles(120);
      check(div_now == 8'(exp_div(10_000_000)), "R2 divisor after start-up", div_now,
            exp_div(10_000_000));
      check_quiet(40, "R6 gated off when idle");
   endtask

   task automatic t_busy_run;
      int hi, per;
      xfer_busy = 1'b1;
      cycles(5);
      check(clk_on == 1'b1, "R6 runs during transaction", clk_on, 1);
      measure(hi, per);
      check(per == 5, "R1 period at divisor 4", per, 5);
      check(hi == 2, "R9 high time at divisor 4", hi, 2);
   endtask

   task automatic t_defer;
      int hi, per;
      write_rate(400_000);
      cycles(40);
      check(div_now == 8'd4, "R10 divisor held while busy", div_now, 4);
      measure(hi, per);
      check(per == 5, "R10 period held while busy", per, 5);
      @(negedge clk);
      idle_clk_en = 1'b1;
      xfer_busy = 1'b0;
      cycles(30);
      check(div_now == 8'(exp_div(400_000)), "R10 change applied after busy", div_now,
            exp_div(400_000));
      check(clk_on == 1'b1, "R6 idle enable keeps clock", clk_on, 1);
      measure(hi, per);
      check(per == 125, "R1 period at divisor 124", per, 125);
      check(hi == 62, "R9 high time at divisor 124", hi, 62);
   endtask

   task automatic t_clamp;
      int hi, per;
      write_rate(25_000_000);
      cycles(300);
      check(div_now == 8'd2, "R8 clamp to maximum rate", div_now, 2);
      measure(hi, per);
      check(per == 3 && hi == 1, "R8 period at maximum rate", per, 3);
   endtask

   task automatic t_slow;
      int hi, per;
      write_rate(10_000_000);
      slow_req = 1'b1;
      cycles(30);
      check(div_now == 8'd32, "R5 slow ratio applied", div_now, 32);
      measure(hi, per);
      check(per == 33 && hi == 16, "R5 slow period", per, 33);
      write_rate(400_000);
      cycles(60);
      check(div_now == 8'd255, "R5 slow ratio saturates", div_now, 255);
      measure(hi, per);
      check(per == 256 && hi == 128, "R1 period at divisor 255", per, 256);
      slow_req = 1'b0;
   endtask

   task automatic t_low_and_odd;
      int hi, per;
      write_rate(100_000);
      cycles(300);
      check(div_now == 8'd255, "R2 below minimum rate", div_now, 255);
      write_rate(7_000_000);
      cycles(300);
      check(div_now == 8'(exp_div(7_000_000)), "R2 rounding down", div_now,
            exp_div(7_000_000));
      measure(hi, per);
      check(per == 8 && hi == 4, "R1 period at divisor 7", per, 8);
   endtask

   task automatic t_gate_stop;
      @(negedge clk);
      idle_clk_en = 1'b0;
      cycles(20);
      check_quiet(30, "R6 stops when idle enable drops");
   endtask

   task automatic t_power_drop;
      @(negedge clk);
      idle_clk_en = 1'b1;
      cycles(20);
      check(clk_on == 1'b1, "R6 running before power drop", clk_on, 1);
      card_pwr = 1'b0;
      @(negedge clk);
      check(!sd_clk && !clk_on, "R7 clock stops the cycle after power off", sd_clk, 0);
      check_quiet(40, "R7 stays quiet while unpowered");
      idle_clk_en = 1'b0;
      card_pwr = 1'b1;
      cycles(10);
      check(div_now == 8'd49 && clk_on, "R4 start-up phase again after repower", div_now, 49);
   endtask

   task automatic t_monitors;
      check(mon_loads > 3 && mon_bad_load == 0, "R3 loads only while stopped",
            mon_bad_load, 0);
      check(mon_pwr_viol == 0, "R7 unpowered clock samples", mon_pwr_viol, 0);
   endtask

   initial begin
      t_reset();
      t_power_off();
      t_powerup_slow();
      t_bulk_ok();
      t_busy_run();
      t_defer();
      t_clamp();
      t_slow();
      t_low_and_odd();
      t_gate_stop();
      t_power_drop();
      t_monitors();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule